// File: doc/BRIEF.md
# Single-line-clocked converter interface sequencer

This block is the digital front end of a four-channel converter that a host reaches over only two lines: a serial clock that the host drives, and a data line that the block drives. The line is high at rest. When it falls, a conversion starts and the two channel-select inputs are captured. Further falls during a timed window after the start each remove one bit of resolution, down to a floor of six removals, and each accepted fall is acknowledged on the data line. The data line is low while the block is busy and goes high when the result is ready. Later falls then shift the result out, sign first.

The analog modulator is not modelled. A result word input stands in for it and is sampled at the moment the conversion ends. A cycle counter stands in for the conversion time, which shrinks with each removed bit by a fixed set of ratios. The window length and the full-resolution conversion time are parameters counted in system clock cycles. The serial clock is asynchronous and passes through a flop synchroniser before its edges are detected. The channel-select inputs are sampled in the same cycle that the synchronised fall is seen, so they must stay stable until then.

Top module: `sclk_conv_seq`

## Requirements
- R1: In the idle state, and also once a result has been fully shifted out, a fall of `sclk_i` starts a conversion. The value on `chan_sel_i` is captured and driven on `chan_o` until the next start. Code 0 selects input 1, 1 selects input 2, 2 selects input 3 and 3 selects input 4.
- R2: After reset, `sdat_o`=1, `sleep_o`=1 and `chan_o`=0. `sleep_o` is 0 from a start until the conversion completes, and 1 otherwise.
- R3: Each fall of `sclk_i` inside the window of `WIN_CYC` cycles after the start removes one bit of resolution. At most `MAX_RED`=6 falls are accepted. Any further fall has no effect on the word length or on the conversion time.
- R4: After an accepted reduction fall, `sdat_o` goes to 1. It returns to 0 when `sclk_i` rises or when the window ends, whichever comes first. A fall that is not accepted leaves `sdat_o` at 0.
- R5: Outside acknowledges, `sdat_o` is 0 from a start until the conversion completes.
- R6: With k accepted reductions, `sdat_o` rises exactly `SYNC_STAGES`+1+`WIN_CYC`+floor(`BASE_CYC`*10/D) clock cycles after the start fall is applied. D is 10, 20, 40, 78, 151, 286 or 514 for k = 0 to 6.
- R7: After completion, the j-th fall of `sclk_i` (j = 1 … 16−k) drives bit 16−j of the captured result on `sdat_o`. The output therefore runs from the sign bit down to bit k, in two's complement.
- R8: A result input of 16'h8000, the reserved code, is captured as 16'h8001. Every other value is captured unchanged.
- R9: While shifting out, the state of the serial clock never starts a new conversion until all 16−k bits have been sent. The fall that follows the last bit is a start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock from the host, asynchronous |
| chan_sel_i | input | 2 | Channel select captured at a start |
| result_i | input | 16 | Stand-in conversion result, sampled at completion |
| sdat_o | output | 1 | Serial data: busy, acknowledge, done and result bits |
| chan_o | output | 2 | Captured channel |
| sleep_o | output | 1 | High when no conversion is running |

## Verification
The sweep covers every requested reduction count from zero to seven, with the channel changing from one conversion to the next. Counts of seven and above show that the cap ignores extra falls, both in the word length and in the timing. Each conversion is timed to the exact cycle, so any error in the duration table or in the window length is exposed. The result patterns are full-scale positive, plus and minus one, zero, the reserved code and mixed bit patterns, and they catch bit-order, truncation and clamping faults. One run holds the clock low after a reduction, which separates an acknowledge that ends with the window from one that ends on the rising clock edge.

// File: rtl/sclk_conv_pkg.sv
package sclk_conv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WIN  = 2'd1,
        ST_CONV = 2'd2,
        ST_READ = 2'd3
    } seq_state_e;

    localparam int unsigned RED_LIMIT = 6;

endpackage

// File: rtl/sclk_conv_sync.sv
module sclk_conv_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level,
    output logic fall,
    output logic rise
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= 1'b1;
                    else        chain_q[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[i] <= 1'b1;
                    else        chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= chain_q[STAGES-1];
    end

    assign level = chain_q[STAGES-1];
    assign fall  = prev_q & ~chain_q[STAGES-1];
    assign rise  = ~prev_q & chain_q[STAGES-1];
endmodule

// File: rtl/sclk_conv_timer.sv
module sclk_conv_timer #(
    parameter int unsigned BASE_CYC = 2056,
    parameter int unsigned CNT_W    = 12,
    parameter int unsigned RED_W    = 3
) (
    input  logic [RED_W-1:0] red,
    output logic [CNT_W-1:0] limit
);
    localparam int unsigned SCALED = BASE_CYC * 10;
    localparam logic [CNT_W-1:0] LIM0 = CNT_W'(SCALED / 10);
    localparam logic [CNT_W-1:0] LIM1 = CNT_W'(SCALED / 20);
    localparam logic [CNT_W-1:0] LIM2 = CNT_W'(SCALED / 40);
    localparam logic [CNT_W-1:0] LIM3 = CNT_W'(SCALED / 78);
    localparam logic [CNT_W-1:0] LIM4 = CNT_W'(SCALED / 151);
    localparam logic [CNT_W-1:0] LIM5 = CNT_W'(SCALED / 286);
    localparam logic [CNT_W-1:0] LIM6 = CNT_W'(SCALED / 514);

    always_comb begin
        case (red)
            RED_W'(0): limit = LIM0;
            RED_W'(1): limit = LIM1;
            RED_W'(2): limit = LIM2;
            RED_W'(3): limit = LIM3;
            RED_W'(4): limit = LIM4;
            RED_W'(5): limit = LIM5;
            default:   limit = LIM6;
        endcase
    end
endmodule

// File: rtl/sclk_conv_word.sv
module sclk_conv_word #(
    parameter int unsigned DATA_W = 16
) (
    input  logic [DATA_W-1:0] raw,
    output logic [DATA_W-1:0] clamped
);
    localparam logic [DATA_W-1:0] RESERVED = {1'b1, {(DATA_W-1){1'b0}}};

    always_comb begin
        if (raw == RESERVED) clamped = RESERVED | DATA_W'(1);
        else                 clamped = raw;
    end
endmodule

// File: rtl/sclk_conv_seq.sv
module sclk_conv_seq
    import sclk_conv_pkg::*;
#(
    parameter int unsigned DATA_W      = 16,
    parameter int unsigned WIN_CYC     = 200,
    parameter int unsigned BASE_CYC    = 2056,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_i,
    input  logic [1:0]        chan_sel_i,
    input  logic [DATA_W-1:0] result_i,
    output logic              sdat_o,
    output logic [1:0]        chan_o,
    output logic              sleep_o
);
    localparam int unsigned MAX_RED = RED_LIMIT;
    localparam int unsigned RED_W   = $clog2(MAX_RED + 1);
    localparam int unsigned CNT_MAX = (WIN_CYC > BASE_CYC) ? WIN_CYC : BASE_CYC;
    localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);
    localparam int unsigned LEFT_W  = $clog2(DATA_W + 1);

    typedef struct packed {
        seq_state_e        st;
        logic [RED_W-1:0]  red;
        logic [CNT_W-1:0]  cnt;
        logic [1:0]        chan;
        logic [DATA_W-1:0] sh;
        logic [LEFT_W-1:0] left;
        logic              sdat;
    } seq_t;

    seq_t q, d;

    logic              s_level, s_fall, s_rise;
    logic [CNT_W-1:0]  conv_lim;
    logic [DATA_W-1:0] word_c;

    sclk_conv_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (sclk_i),
        .level (s_level),
        .fall  (s_fall),
        .rise  (s_rise)
    );

    sclk_conv_timer #(.BASE_CYC(BASE_CYC), .CNT_W(CNT_W), .RED_W(RED_W)) u_timer (
        .red   (q.red),
        .limit (conv_lim)
    );

    sclk_conv_word #(.DATA_W(DATA_W)) u_word (
        .raw     (result_i),
        .clamped (word_c)
    );

    always_comb begin
        d = q;
        case (q.st)
            ST_IDLE: begin
                if (s_fall) begin
                    d.st   = ST_WIN;
                    d.cnt  = '0;
                    d.red  = '0;
                    d.sdat = 1'b0;
                    d.chan = chan_sel_i;
                end
            end
            ST_WIN: begin
                d.cnt = q.cnt + CNT_W'(1);
                if (s_rise) d.sdat = 1'b0;
                if (s_fall && (q.red < RED_W'(MAX_RED))) begin
                    d.red  = q.red + RED_W'(1);
                    d.sdat = 1'b1;
                end
                if (q.cnt == CNT_W'(WIN_CYC - 1)) begin
                    d.st   = ST_CONV;
                    d.cnt  = '0;
                    d.red  = q.red;
                    d.sdat = 1'b0;
                end
            end
            ST_CONV: begin
                d.cnt = q.cnt + CNT_W'(1);
                if (q.cnt == conv_lim - CNT_W'(1)) begin
                    d.st   = ST_READ;
                    d.cnt  = '0;
                    d.sdat = 1'b1;
                    d.sh   = word_c;
                    d.left = LEFT_W'(DATA_W) - LEFT_W'(q.red);
                end
            end
            default: begin
                if (s_fall) begin
                    if (q.left != '0) begin
                        d.sdat = q.sh[DATA_W-1];
                        d.sh   = q.sh << 1;
                        d.left = q.left - LEFT_W'(1);
                    end else begin
                        d.st   = ST_WIN;
                        d.cnt  = '0;
                        d.red  = '0;
                        d.sdat = 1'b0;
                        d.chan = chan_sel_i;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st   <= ST_IDLE;
            q.red  <= '0;
            q.cnt  <= '0;
            q.chan <= 2'd0;
            q.sh   <= '0;
            q.left <= '0;
            q.sdat <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign sdat_o  = q.sdat;
    assign chan_o  = q.chan;
    assign sleep_o = (q.st == ST_IDLE) || (q.st == ST_READ);

    // R3
    red_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.red <= RED_W'(MAX_RED));

    // R5
    busy_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_CONV) |-> !sdat_o);

    // R6
    done_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(q.st) == ST_CONV && q.st == ST_READ) |-> sdat_o);

    // R1
    chan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(chan_o) |-> (q.st == ST_WIN && q.cnt == '0));

    // R7
    left_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_READ) |-> (q.left <= LEFT_W'(DATA_W) - LEFT_W'(q.red)));

    // R4
    ack_low_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_WIN && sdat_o) |-> $past(!s_level));
endmodule

// File: tb/sclk_conv_seq_tb.sv
module sclk_conv_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WIN  = 200;
    localparam int BASE = 2056;
    localparam int SYNC = 2;
    localparam int GAP  = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b1;
    logic [1:0]  csel = 2'd0;
    logic [15:0] res = 16'h0000;
    logic        sdat;
    logic [1:0]  chan;
    logic        sleep;

    int errors = 0;
    int checks = 0;
    int cyc = 0;

    sclk_conv_seq #(.DATA_W(16), .WIN_CYC(WIN), .BASE_CYC(BASE), .SYNC_STAGES(SYNC)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk_i     (sclk),
        .chan_sel_i (csel),
        .result_i   (res),
        .sdat_o     (sdat),
        .chan_o     (chan),
        .sleep_o    (sleep)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    task automatic gap();
        repeat (GAP) @(negedge clk);
    endtask

    function automatic int conv_len(int k);
        int dv;
        case (k)
            0: dv = 10;
            1: dv = 20;
            2: dv = 40;
            3: dv = 78;
            4: dv = 151;
            5: dv = 286;
            default: dv = 514;
        endcase
        return (BASE * 10) / dv;
    endfunction

    task automatic do_conv(input logic [1:0] ch, input logic [15:0] value,
                           input int edges, input bit hold_last);
        int t0;
        int k;
        int exp_t;
        int nbits;
        logic [15:0] word;
        bit done;
        k = (edges > 6) ? 6 : edges;
        csel = ch;
        res = value;
        t0 = cyc;
        sclk = 1'b0;
        gap();
        chk("R1 chan", int'(chan), int'(ch));
        chk("R5 busy after start", int'(sdat), 0);
        chk("R2 sleep low", int'(sleep), 0);
        csel = ~ch;
        sclk = 1'b1;
        gap();
        for (int e = 0; e < edges; e++) begin
            sclk = 1'b0;
            gap();
            chk("R4 ack on fall", int'(sdat), (e < 6) ? 1 : 0);
            if (hold_last && e == edges - 1) begin
                repeat (WIN) @(negedge clk);
                chk("R4 ack ends with window", int'(sdat), 0);
            end
            sclk = 1'b1;
            gap();
            chk("R4 ack cleared", int'(sdat), 0);
        end
        done = 1'b0;
        while (!done && (cyc - t0) < 4000) begin
            @(negedge clk);
            if (sdat) done = 1'b1;
        end
        exp_t = SYNC + 1 + WIN + conv_len(k);
        chk("R6 conversion time", cyc - t0, exp_t);
        chk("R2 sleep after done", int'(sleep), 1);
        chk("R1 chan held", int'(chan), int'(ch));
        word = (value == 16'h8000) ? 16'h8001 : value;
        nbits = 16 - k;
        for (int j = 1; j <= nbits; j++) begin
            sclk = 1'b0;
            gap();
            if (value == 16'h8000 && k == 0)
                chk("R8 reserved bit", int'(sdat), int'(word[16-j]));
            else
                chk("R7 data bit", int'(sdat), int'(word[16-j]));
            sclk = 1'b1;
            gap();
            chk("R9 no restart", int'(sleep), 1);
        end
    endtask

    initial begin
        logic [15:0] pats [8];
        pats[0] = 16'h7FFF; pats[1] = 16'h0001; pats[2] = 16'h0000; pats[3] = 16'hFFFF;
        pats[4] = 16'h8000; pats[5] = 16'hA5C3; pats[6] = 16'h1234; pats[7] = 16'h8001;
        repeat (3) @(negedge clk);
        chk("R2 reset sdat", int'(sdat), 1);
        chk("R2 reset sleep", int'(sleep), 1);
        chk("R2 reset chan", int'(chan), 0);
        rst_n = 1'b1;
        gap();
        chk("R2 idle sdat", int'(sdat), 1);
        for (int k = 0; k < 8; k++) begin
            do_conv(2'(k), pats[k], k, 1'b0);
        end
        do_conv(2'd2, 16'h8000, 0, 1'b0);
        do_conv(2'd1, 16'h5A5A, 1, 1'b1);
        do_conv(2'd3, 16'hC001, 9, 1'b0);
        do_conv(2'd0, 16'h7FFF, 3, 1'b0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule